// File: doc/BRIEF.md
# Shared Memory Byte-Parity Checker

This block sits between the requesters of a shared DRAM and the array itself. It protects each byte lane with one parity bit. On the write path it adds a parity bit to every byte on its way to the array. On the read path it checks every enabled byte against its stored parity bit, then returns a registered response to the requester.

Two kinds of requester use the memory: the local processor, and an external system bus acting as a slave. When a read fails its check, the response depends on the requester. An external read is refused with a bus error. A local access still completes normally, and a held interrupt request goes out at a level that software chose. The first failing access leaves its address and its origin in a log register, which stays frozen until software clears it.

The read data path is valid/ready. A read is taken when `rd_valid` and `rd_ready` are both high at a clock edge. `rd_ready` stays low while a response is waiting and `rsp_ready` is low, so a stalled consumer stops the reads behind it. The write path passes straight through, so back-pressure from the array reaches the writer in the same cycle.

Top module: `shmem_parity_guard`

## Requirements
- R1: For every lane i (data bits 8i+7..8i), `mem_w_par[i]` is set so that the byte and its parity bit together hold an odd number of ones.
- R2: `mem_w_valid`, `mem_w_data` and `mem_w_be` follow `w_valid`, `w_data` and `w_be` in the same cycle. `w_ready` follows `mem_w_ready`.
- R3: A lane fails its check only when its bit in `rd_be` is 1 and the byte together with its `rd_par` bit holds an even number of ones. A lane whose strobe is 0 never raises an error.
- R4: A read taken at an edge appears on `rsp_valid`/`rsp_data` right after that edge. `rd_ready` equals `!rsp_valid || rsp_ready`. A response held under back-pressure keeps its value.
- R5: An external read (`rd_ext`=1) that fails its check returns `rsp_berr`=1 and `rsp_ack`=0.
- R6: A local read (`rd_ext`=0) that fails its check still returns `rsp_ack`=1 and `rsp_berr`=0.
- R7: A read with no failing lane returns `rsp_ack`=1 and `rsp_berr`=0, whatever its origin, with the data unchanged.
- R8: When a read that fails its check is taken, and the log is clear, the log is filled after that edge. `err_flag` becomes 1, `err_addr` takes `rd_addr`, and `err_ext` takes `rd_ext`.
- R9: While `err_flag` is 1, later failing reads change neither `err_addr` nor `err_ext`.
- R10: A pulse on `sw_clr` clears `err_flag` at the next edge. If a failing read is taken at that same edge, the new read is logged.
- R11: `irq_req` is 1 exactly when `err_flag` is 1 and the logged origin is local. `irq_level` shows the last value written through `sw_level_we`/`sw_level_wdata`.
- R12: After reset, `rsp_valid`, `err_flag`, `irq_req` and `irq_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| w_valid | input | 1 | Write beat offered |
| w_ready | output | 1 | Write beat taken by the array |
| w_data | input | DATA_W | Write data |
| w_be | input | DATA_W/8 | Write byte strobes |
| mem_w_valid | output | 1 | Write beat to the array |
| mem_w_ready | input | 1 | Array accepts the write beat |
| mem_w_data | output | DATA_W | Write data to the array |
| mem_w_be | output | DATA_W/8 | Byte strobes to the array |
| mem_w_par | output | DATA_W/8 | Per-lane odd parity bits |
| rd_valid | input | 1 | Read data from the array is valid |
| rd_ready | output | 1 | Checker can take read data |
| rd_data | input | DATA_W | Read data |
| rd_par | input | DATA_W/8 | Stored parity bits |
| rd_be | input | DATA_W/8 | Lanes that the access uses |
| rd_addr | input | ADDR_W | Address of the access |
| rd_ext | input | 1 | 1 = external bus slave access, 0 = local |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Returned data |
| rsp_ack | output | 1 | Normal termination |
| rsp_berr | output | 1 | Bus error termination |
| sw_clr | input | 1 | Write-one-to-clear of the error log |
| sw_level_we | input | 1 | Load the interrupt level |
| sw_level_wdata | input | LVL_W | New interrupt level |
| err_flag | output | 1 | Sticky error flag |
| err_addr | output | ADDR_W | Logged faulting address |
| err_ext | output | 1 | Logged origin, 1 = external |
| irq_req | output | 1 | Interrupt request for a local error |
| irq_level | output | LVL_W | Interrupt level |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=16 and LVL_W=3. The four lanes let it corrupt a single lane and place that lane inside or outside the enabled strobes. It can also mix several bad lanes in one word. The 16-bit address space is enough to tell the first logged address apart from later ones. With three level bits, a non-zero, non-trivial level can be seen on `irq_level`.

// File: rtl/shpar_pkg.sv
package shpar_pkg;
  typedef enum logic { ORG_LOCAL = 1'b0, ORG_EXT = 1'b1 } origin_e;
  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/shpar_lane_gen.sv
module shpar_lane_gen #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*shpar_pkg::LANE_BITS-1:0] data,
  output logic [LANES-1:0]                      par
);
  localparam int unsigned LB = shpar_pkg::LANE_BITS;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = ~^data[g*LB +: LB];
  end
endmodule

// File: rtl/shpar_lane_chk.sv
module shpar_lane_chk #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES*shpar_pkg::LANE_BITS-1:0] data,
  input  logic [LANES-1:0]                      par,
  input  logic [LANES-1:0]                      be,
  output logic [LANES-1:0]                      lane_bad
);
  localparam int unsigned LB = shpar_pkg::LANE_BITS;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = be[g] & ~(^{par[g], data[g*LB +: LB]});
  end
endmodule

// File: rtl/shpar_err_log.sv
module shpar_err_log #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  shpar_pkg::origin_e evt_org,
  input  logic              sw_clr,
  input  logic              sw_level_we,
  input  logic [LVL_W-1:0]  sw_level_wdata,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_ext,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level
);
  import shpar_pkg::*;

  logic     flag_q;
  logic [ADDR_W-1:0] addr_q;
  origin_e  org_q;
  logic [LVL_W-1:0]  lvl_q;
  logic     take;

  // A clear in the same cycle frees the log for the incoming event.
  assign take = evt && (!flag_q || sw_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      org_q  <= ORG_LOCAL;
    end else if (take) begin
      flag_q <= 1'b1;
      addr_q <= evt_addr;
      org_q  <= evt_org;
    end else if (sw_clr) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lvl_q <= '0;
    else if (sw_level_we) lvl_q <= sw_level_wdata;
  end

  assign err_flag  = flag_q;
  assign err_addr  = addr_q;
  assign err_ext   = (org_q == ORG_EXT);
  assign irq_req   = flag_q && (org_q == ORG_LOCAL);
  assign irq_level = lvl_q;
endmodule

// File: rtl/shmem_parity_guard.sv
module shmem_parity_guard #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [DATA_W/8-1:0] w_be,
  output logic              mem_w_valid,
  input  logic              mem_w_ready,
  output logic [DATA_W-1:0] mem_w_data,
  output logic [DATA_W/8-1:0] mem_w_be,
  output logic [DATA_W/8-1:0] mem_w_par,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W/8-1:0] rd_par,
  input  logic [DATA_W/8-1:0] rd_be,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ext,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ack,
  output logic              rsp_berr,
  input  logic              sw_clr,
  input  logic              sw_level_we,
  input  logic [LVL_W-1:0]  sw_level_wdata,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr,
  output logic              err_ext,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level
);
  import shpar_pkg::*;
  localparam int unsigned LANES = DATA_W / LANE_BITS;

  // Write path: straight through, parity appended.
  assign mem_w_valid = w_valid;
  assign w_ready     = mem_w_ready;
  assign mem_w_data  = w_data;
  assign mem_w_be    = w_be;

  shpar_lane_gen #(.LANES(LANES)) u_gen (
    .data (w_data),
    .par  (mem_w_par)
  );

  // Read path: check, then one response register.
  logic [LANES-1:0] lane_bad;
  logic             any_bad;
  logic             rd_fire;
  logic             vq;
  logic [DATA_W-1:0] dq;
  logic             ackq;
  logic             berrq;
  origin_e          rd_org;

  shpar_lane_chk #(.LANES(LANES)) u_chk (
    .data     (rd_data),
    .par      (rd_par),
    .be       (rd_be),
    .lane_bad (lane_bad)
  );

  assign any_bad  = |lane_bad;
  assign rd_org   = rd_ext ? ORG_EXT : ORG_LOCAL;
  assign rd_ready = !vq || rsp_ready;
  assign rd_fire  = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq    <= 1'b0;
      dq    <= '0;
      ackq  <= 1'b0;
      berrq <= 1'b0;
    end else if (rd_fire) begin
      vq    <= 1'b1;
      dq    <= rd_data;
      berrq <= any_bad && (rd_org == ORG_EXT);
      ackq  <= !(any_bad && (rd_org == ORG_EXT));
    end else if (rsp_ready) begin
      vq    <= 1'b0;
    end
  end

  assign rsp_valid = vq;
  assign rsp_data  = dq;
  assign rsp_ack   = ackq;
  assign rsp_berr  = berrq;

  shpar_err_log #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_log (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt            (rd_fire && any_bad),
    .evt_addr       (rd_addr),
    .evt_org        (rd_org),
    .sw_clr         (sw_clr),
    .sw_level_we    (sw_level_we),
    .sw_level_wdata (sw_level_wdata),
    .err_flag       (err_flag),
    .err_addr       (err_addr),
    .err_ext        (err_ext),
    .irq_req        (irq_req),
    .irq_level      (irq_level)
  );
endmodule

// File: rtl/shpar_guard_chk.sv
module shpar_guard_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_ack,
  input logic              rsp_berr,
  input logic              sw_clr,
  input logic              err_flag,
  input logic [ADDR_W-1:0] err_addr,
  input logic              err_ext,
  input logic              irq_req
);
  AST_ONE_TERMINATION: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ack, rsp_berr}) == 1); // R5
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_berr) && $stable(rsp_ack)); // R4
  AST_STALL_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rd_ready); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> err_flag && !err_ext); // R11
  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !sw_clr |=> err_flag && $stable(err_addr) && $stable(err_ext)); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr && !(rd_valid && rd_ready) |=> !err_flag); // R10
endmodule

bind shmem_parity_guard shpar_guard_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_guard_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_ack   (rsp_ack),
  .rsp_berr  (rsp_berr),
  .sw_clr    (sw_clr),
  .err_flag  (err_flag),
  .err_addr  (err_addr),
  .err_ext   (err_ext),
  .irq_req   (irq_req)
);

// File: tb/test_shmem_parity_guard.sv
module test_shmem_parity_guard;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int LW = 3;
  localparam int NL = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic w_valid = 0, mem_w_ready = 0, rd_valid = 0, rd_ext = 0, rsp_ready = 1;
  logic sw_clr = 0, sw_level_we = 0;
  logic [DW-1:0] w_data = '0, rd_data = '0;
  logic [NL-1:0] w_be = '0, rd_par = '0, rd_be = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [LW-1:0] sw_level_wdata = '0;
  logic w_ready, mem_w_valid, rd_ready, rsp_valid, rsp_ack, rsp_berr;
  logic err_flag, err_ext, irq_req;
  logic [DW-1:0] mem_w_data, rsp_data;
  logic [NL-1:0] mem_w_be, mem_w_par;
  logic [AW-1:0] err_addr;
  logic [LW-1:0] irq_level;

  shmem_parity_guard #(.DATA_W(DW), .ADDR_W(AW), .LVL_W(LW)) i_shmem_parity_guard (
    .clk(clk), .rst_n(rst_n),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_be(w_be),
    .mem_w_valid(mem_w_valid), .mem_w_ready(mem_w_ready), .mem_w_data(mem_w_data),
    .mem_w_be(mem_w_be), .mem_w_par(mem_w_par),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_par(rd_par),
    .rd_be(rd_be), .rd_addr(rd_addr), .rd_ext(rd_ext),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_ack(rsp_ack), .rsp_berr(rsp_berr),
    .sw_clr(sw_clr), .sw_level_we(sw_level_we), .sw_level_wdata(sw_level_wdata),
    .err_flag(err_flag), .err_addr(err_addr), .err_ext(err_ext),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit stall_mode = 0;
  logic [DW+1:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] good_par(input logic [DW-1:0] d);
    logic [NL-1:0] p;
    for (int i = 0; i < NL; i++) p[i] = ((($countones(d[i*8 +: 8])) % 2) == 0);
    return p;
  endfunction

  // Driver: pushes the expected response, then offers the read.
  task automatic rd(input bit ext, input logic [AW-1:0] a, input logic [NL-1:0] be,
                    input logic [DW-1:0] d, input logic [NL-1:0] flip, input bit with_clr);
    bit bad;
    bit ok;
    bad = |(flip & be);
    expq.push_back({d, ext && bad, !(ext && bad)});
    rd_valid = 1; rd_ext = ext; rd_addr = a; rd_be = be; rd_data = d;
    rd_par = good_par(d) ^ flip; sw_clr = with_clr;
    forever begin
      #1 ok = rd_ready;
      @(negedge clk);
      sw_clr = 0;
      if (ok) break;
    end
    rd_valid = 0;
  endtask

  // Response consumer pattern.
  int unsigned lf = 32'h1;
  always @(negedge clk) begin
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    rsp_ready = stall_mode ? lf[0] : 1'b1;
  end

  // Monitor: compare each transferred response with the scoreboard.
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) chk(0, "R4", "unexpected response", 1, 0);
      else begin
        logic [DW+1:0] e;
        e = expq.pop_front();
        chk(rsp_data == e[DW+1:2], "R7", "rsp_data", rsp_data, e[DW+1:2]);
        chk(rsp_berr == e[1], "R5", "rsp_berr", rsp_berr, e[1]);
        chk(rsp_ack == e[0], "R6", "rsp_ack", rsp_ack, e[0]);
      end
    end
  end

  bit finished = 0;
  initial begin
    #(200000 * 20);
    if (!finished) begin
      chk(0, "R12", "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 0, "R12", "rsp_valid", rsp_valid, 0);
    chk(err_flag == 0, "R12", "err_flag", err_flag, 0);
    chk(irq_req == 0, "R12", "irq_req", irq_req, 0);
    chk(irq_level == 0, "R12", "irq_level", irq_level, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 / R2 write path
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] d;
      d = 32'h0107_FF00 ^ (32'h1357_9BDF * k);
      w_valid = k[0]; w_data = d; w_be = NL'(k + 3); mem_w_ready = k[1];
      #1;
      chk(mem_w_par == good_par(d), "R1", "mem_w_par", mem_w_par, good_par(d));
      chk(mem_w_data == d && mem_w_be == w_be && mem_w_valid == w_valid && w_ready == mem_w_ready,
          "R2", "write passthrough", mem_w_data, d);
      @(negedge clk);
    end
    w_valid = 0;

    // R7 clean reads of both origins
    rd(0, 16'h0100, 4'hF, 32'hDEAD_BEEF, 4'h0, 0);
    rd(1, 16'h0104, 4'hF, 32'h0000_0001, 4'h0, 0);
    chk(err_flag == 0, "R7", "no log on clean reads", err_flag, 0);

    // R5 / R8 external error in lane 2
    rd(1, 16'h2A40, 4'hF, 32'h1234_5678, 4'h4, 0);
    chk(err_flag == 1, "R8", "err_flag", err_flag, 1);
    chk(err_addr == 16'h2A40, "R8", "err_addr", err_addr, 16'h2A40);
    chk(err_ext == 1, "R8", "err_ext", err_ext, 1);
    chk(irq_req == 0, "R11", "no irq for external", irq_req, 0);

    // R10 clear
    sw_clr = 1; @(negedge clk); sw_clr = 0;
    chk(err_flag == 0, "R10", "cleared", err_flag, 0);

    // R3 bad lane outside the strobes
    rd(1, 16'h0200, 4'h3, 32'hAAAA_5555, 4'h8, 0);
    rd(0, 16'h0204, 4'h0, 32'h0F0F_0F0F, 4'hF, 0);
    chk(err_flag == 0, "R3", "masked lanes ignored", err_flag, 0);

    // R6 / R11 local error with a chosen level
    sw_level_we = 1; sw_level_wdata = 3'd5; @(negedge clk); sw_level_we = 0;
    chk(irq_level == 5, "R11", "irq_level", irq_level, 5);
    rd(0, 16'h3300, 4'h5, 32'h8000_0001, 4'h5, 0);
    chk(irq_req == 1, "R6", "irq on local error", irq_req, 1);
    chk(err_addr == 16'h3300 && err_ext == 0, "R8", "local log", err_addr, 16'h3300);

    // R9 later error ignored
    rd(1, 16'h4400, 4'hF, 32'h7777_7777, 4'h1, 0);
    chk(err_addr == 16'h3300, "R9", "addr frozen", err_addr, 16'h3300);
    chk(err_ext == 0 && irq_req == 1, "R9", "origin frozen", err_ext, 0);

    // R10 clear together with a new error
    repeat (2) @(negedge clk);
    rd(1, 16'h5500, 4'hF, 32'h0000_FFFF, 4'h2, 1);
    chk(err_flag == 1 && err_addr == 16'h5500, "R10", "new error logged on clear", err_addr, 16'h5500);
    chk(irq_req == 0, "R11", "irq drops for external log", irq_req, 0);
    sw_clr = 1; @(negedge clk); sw_clr = 0;
    chk(irq_req == 0 && err_flag == 0, "R11", "irq after clear", irq_req, 0);

    // R4 back-pressure burst
    stall_mode = 1;
    for (int k = 0; k < 24; k++)
      rd(k[0], AW'(k * 4), 4'hF, 32'hC0DE_0000 + k, (k % 5 == 0) ? 4'h2 : 4'h0, 0);
    stall_mode = 0;
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R4", "all responses delivered", expq.size(), 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule